// File: doc/BRIEF.md
# Slot Power Control and Status Register

This block is the control and status register of one hot-plug power slot. Software writes the enables for the slot's main and auxiliary outputs through a small register bus. It also writes a bit that decides whether an external active-low force-on pin is allowed to act. The block reports whether each output has risen above its undervoltage threshold and drives the active-low, open-drain power-good pin of the slot.

The two undervoltage comparator results and the force-on pin are asynchronous to the register clock, so each passes through a synchronizer before it is used. The power-good pin is pulled low (power good) only when both outputs are good. The force-on pin can hold the pin released (power not good), and it can do so only while the register permits it. The status bits that software reads always show the true comparator state and never the override. The analog detection and the serial bus decoding are not part of this block.

Top module: `slot_pwr_ctl`

## Requirements
- R1: After reset, main_en and aux_en are 0, pgood_pull is 0, and a read of the register returns 0x00 until a status input has been high for two clock edges.
- R2: A write (wr_en high while cmd_sel equals 0x03) stores wr_data bit 0 as the aux enable, bit 1 as the main enable and bit 2 as the force-disable bit. main_en and aux_en follow the stored bits from the clock edge of the write onward (1 = on, 0 = off).
- R3: Register bits 7 to 3 are read-only. Write data in those positions has no effect, and bits 5 to 3 always read as 0.
- R4: A wr_en pulse with any cmd_sel other than 0x03 changes no stored bit.
- R5: While cmd_sel equals 0x03, rd_data shows the register byte in the same cycle. For any other cmd_sel it shows 0x00. Bits 2 to 0 read back what was last written.
- R6: rd_data bit 7 shows aux_ok and bit 6 shows main_ok, each delayed by exactly two clock edges through a synchronizer.
- R7: With no force override, pgood_pull is 1 (pin pulled low, power good) exactly when both synchronized status bits are 1.
- R8: When the synchronized force_on_n is 0 and the force-disable bit is 0, pgood_pull is 0 (pin released, power not good) whatever the status.
- R9: When the force-disable bit is 1, force_on_n has no effect on pgood_pull.
- R10: The status bits 7 and 6 read the same whatever the level of force_on_n or the force-disable bit.
- R11: force_on_n passes through the same two-edge synchronizer before it can act on pgood_pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sel | input | 8 | Command byte that selects the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Register byte while selected, otherwise 0x00 |
| main_ok | input | 1 | Main outputs above undervoltage threshold (asynchronous) |
| aux_ok | input | 1 | Aux output above undervoltage threshold (asynchronous) |
| force_on_n | input | 1 | Active-low force-on pin (asynchronous) |
| main_en | output | 1 | Main output enable |
| aux_en | output | 1 | Aux output enable |
| pgood_pull | output | 1 | 1 pulls the open-drain power-good pin low (power good) |

## Verification
Results come due at three different times. A stored enable bit appears on main_en, aux_en and rd_data right after the clock edge that takes the write. A change on aux_ok, main_ok or force_on_n reaches rd_data and pgood_pull only after the second clock edge. The cmd_sel decode on rd_data is combinational in the same cycle. The bench drives every input on a falling edge and compares on the next falling edge. Its reference model keeps its own two-deep pipeline of the asynchronous inputs and applies writes at the rising edge between drive and compare, so every compare sees exactly the latency each requirement states.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
   localparam int REG_W       = 8;
   localparam int CTL_W       = 3;
   localparam int BIT_AUX_PG  = 7;
   localparam int BIT_MAIN_PG = 6;
   localparam int BIT_FRC_DIS = 2;
   localparam int BIT_MAIN_EN = 1;
   localparam int BIT_AUX_EN  = 0;

   typedef struct packed {
      logic frc_dis;
      logic main_on;
      logic aux_on;
   } slot_ctl_t;

   typedef struct packed {
      logic aux_good;
      logic main_good;
      logic force_n;
   } slot_pins_t;
endpackage

// File: rtl/slot_pwr_sync.sv
module slot_pwr_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("slot_pwr_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/slot_pwr_ctl_reg.sv
module slot_pwr_ctl_reg
   import slot_pwr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [REG_W-1:0] wdata,
   output slot_ctl_t        ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_hit) begin
         ctl.frc_dis <= wdata[BIT_FRC_DIS];
         ctl.main_on <= wdata[BIT_MAIN_EN];
         ctl.aux_on  <= wdata[BIT_AUX_EN];
      end
   end

   // R2: a hit lands its low bits in the next cycle
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> ctl == $past(wdata[CTL_W-1:0]));

   // R4: without a hit nothing moves
   p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(ctl));
endmodule

// File: rtl/slot_pwr_pgood.sv
module slot_pwr_pgood
   import slot_pwr_pkg::*;
#(
   parameter bit FORCE_GATEABLE = 1'b1
) (
   input  slot_pins_t pins,
   input  logic       frc_dis,
   output logic       pull_low
);
   logic force_act;

   if (FORCE_GATEABLE) begin : g_gated
      assign force_act = !pins.force_n && !frc_dis;
   end else begin : g_always
      assign force_act = !pins.force_n;
   end

   assign pull_low = pins.aux_good && pins.main_good && !force_act;
endmodule

// File: rtl/slot_pwr_ctl.sv
module slot_pwr_ctl
   import slot_pwr_pkg::*;
#(
   parameter int         CMD_W     = 8,
   parameter logic [CMD_W-1:0] CMD_SEL = 8'h03,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd_sel,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             main_ok,
   input  logic             aux_ok,
   input  logic             force_on_n,
   output logic             main_en,
   output logic             aux_en,
   output logic             pgood_pull
);
   localparam int PIN_W = $bits(slot_pins_t);
   localparam slot_pins_t PIN_RST = '{aux_good: 1'b0, main_good: 1'b0, force_n: 1'b1};

   if (CMD_W < 1) begin : g_bad_cmd
      $error("slot_pwr_ctl: CMD_W must be positive");
   end

   logic       sel;
   logic       wr_hit;
   slot_ctl_t  ctl;
   slot_pins_t pins_raw;
   slot_pins_t pins_s;
   logic [PIN_W-1:0] pins_q;
   logic [REG_W-1:0] reg_byte;

   assign sel    = (cmd_sel == CMD_SEL);
   assign wr_hit = wr_en && sel;

   assign pins_raw = '{aux_good: aux_ok, main_good: main_ok, force_n: force_on_n};

   slot_pwr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_q)
   );
   assign pins_s = slot_pins_t'(pins_q);

   slot_pwr_ctl_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(wr_hit),
      .wdata (wr_data),
      .ctl   (ctl)
   );

   slot_pwr_pgood #(.FORCE_GATEABLE(1'b1)) u_pg (
      .pins    (pins_s),
      .frc_dis (ctl.frc_dis),
      .pull_low(pgood_pull)
   );

   always_comb begin
      reg_byte              = '0;
      reg_byte[BIT_AUX_PG]  = pins_s.aux_good;
      reg_byte[BIT_MAIN_PG] = pins_s.main_good;
      reg_byte[CTL_W-1:0]   = ctl;
   end

   assign rd_data = sel ? reg_byte : '0;
   assign main_en = ctl.main_on;
   assign aux_en  = ctl.aux_on;

   // R7: the pin is never pulled low unless both synchronized status bits are good
   p_pull_needs_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_pull |-> (pins_s.aux_good && pins_s.main_good));

   // R8: an allowed force request keeps the pin released
   p_force_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_s.force_n && !ctl.frc_dis) |-> !pgood_pull);

   // R3: reserved positions read as zero
   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5:3] == 3'b000);
endmodule

// File: tb/slot_pwr_ctl_test.sv
module slot_pwr_ctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cmd_sel = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       main_ok = 1'b0;
   logic       aux_ok = 1'b0;
   logic       force_on_n = 1'b1;
   logic       main_en;
   logic       aux_en;
   logic       pgood_pull;

   int n_checks = 0;
   int n_fail   = 0;

   // model state
   logic [2:0] m_ctl = 3'b000;
   logic [2:0] m_s1  = 3'b001;   // {aux, main, force_n}
   logic [2:0] m_s2  = 3'b001;

   always #2.5 clk = ~clk;   // 200 MHz

   slot_pwr_ctl uut (
      .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .main_ok(main_ok), .aux_ok(aux_ok),
      .force_on_n(force_on_n), .main_en(main_en), .aux_en(aux_en),
      .pgood_pull(pgood_pull)
   );

   function automatic logic [7:0] exp_rd(input logic [7:0] cmd, input logic [2:0] s, input logic [2:0] c);
      return (cmd == 8'h03) ? {s[2], s[1], 3'b000, c} : 8'h00;
   endfunction

   function automatic logic exp_pg(input logic [2:0] s, input logic [2:0] c);
      logic forced;
      forced = !s[0] && !c[2];
      return s[2] && s[1] && !forced;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [7:0] cmd, input logic wr, input logic [7:0] wd,
                       input logic a, input logic m, input logic f, input string tag);
      @(negedge clk);
      cmd_sel = cmd; wr_en = wr; wr_data = wd;
      aux_ok = a; main_ok = m; force_on_n = f;
      @(posedge clk);
      if (wr && cmd == 8'h03) m_ctl = wd[2:0];
      m_s2 = m_s1;
      m_s1 = {a, m, f};
      @(negedge clk);
      chk({tag, " R5 R6 R10 rd_data"}, rd_data, exp_rd(cmd, m_s2, m_ctl));
      chk({tag, " R2 main_en"}, {7'd0, main_en}, {7'd0, m_ctl[1]});
      chk({tag, " R2 aux_en"}, {7'd0, aux_en}, {7'd0, m_ctl[0]});
      chk({tag, " R7 R8 R9 R11 pgood_pull"}, {7'd0, pgood_pull}, {7'd0, exp_pg(m_s2, m_ctl)});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4711));
      cmd_sel = 8'h03;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 enables", {6'd0, main_en, aux_en}, 8'h00);
      chk("R1 pgood_pull", {7'd0, pgood_pull}, 8'h00);
      rst_n = 1'b1;

      // R1: status not visible until two edges
      step(8'h03, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R1 first edge");
      chk("R1 status after one edge", rd_data, 8'h00);
      step(8'h03, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R6 second edge");
      chk("R6 status after two edges", rd_data, 8'hC0);
      chk("R7 both good", {7'd0, pgood_pull}, 8'h01);

      // R2 enables on, R3 read-only bits ignored
      step(8'h03, 1'b1, 8'hFB, 1'b1, 1'b1, 1'b1, "R3 write ro");
      chk("R3 ro ignored", rd_data, 8'hC3);
      // R4 wrong command
      step(8'h04, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, "R4 other cmd");
      chk("R4 other cmd reads zero R5", rd_data, 8'h00);
      step(8'h03, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R4 readback");
      chk("R4 bits kept", rd_data, 8'hC3);

      // R8 force active with force-disable 0
      step(8'h03, 1'b1, 8'h03, 1'b1, 1'b1, 1'b0, "R11 force edge1");
      chk("R11 force not yet seen", {7'd0, pgood_pull}, 8'h01);
      step(8'h03, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R8 force edge2");
      chk("R8 forced released", {7'd0, pgood_pull}, 8'h00);
      chk("R10 status under force", rd_data, 8'hC3);
      // R9 force ignored with force-disable 1
      step(8'h03, 1'b1, 8'h07, 1'b1, 1'b1, 1'b0, "R9 disable force");
      chk("R9 force ignored", {7'd0, pgood_pull}, 8'h01);
      chk("R10 status with disable", rd_data, 8'hC7);
      // R7 one status low
      step(8'h03, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 aux low e1");
      step(8'h03, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 aux low e2");
      chk("R7 aux low", {7'd0, pgood_pull}, 8'h00);
      // R2 enables off
      step(8'h03, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, "R2 all off");
      chk("R2 off", {6'd0, main_en, aux_en}, 8'h00);

      for (int i = 0; i < 400; i++) begin
         logic [7:0] c;
         c = ($urandom % 3 == 0) ? 8'($urandom) : 8'h03;
         step(c, 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "random");
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule